// File: doc/BRIEF.md
# Two-level microcoded byte machine

This block is a small byte-wide machine driven by a two-level control scheme. A microprogram lives in a byte memory addressed by a 16-bit address counter. Each microinstruction starts with an opcode byte. That byte is loaded into an opcode register, and the opcode then selects a short nanoprogram of up to sixteen steps. The word for each nanostep comes from a control table addressed by the opcode, a 4-bit phase counter and one condition bit. The word names one source that drives the shared 8-bit bus in that step and one destination that captures it. It also carries an ALU operation code, a condition-code action, an address-increment flag and a flag that picks which half of the address counter a bus load writes.

Any control table entry that is not programmed yields the fetch word. The fetch word reads the next microprogram byte into the opcode register and advances the address counter. An opcode without its own nanoprogram therefore acts as a one-step no-operation, and every nanoprogram ends by falling into a fetch. The destinations are the opcode register, the address counter, two operand registers A and B, a data-memory address register and a 256-byte data RAM. The microprogram memory and the data RAM are internal arrays, and the environment fills them through a preload port while the machine is held in reset.

Top module: `nseq_core`

## Requirements
- R1: While `rst_n` is low the address counter, phase and step indicator read 0 and the opcode register holds 00, which has no nanoprogram. The reset release passes through a two-flop synchroniser. The first nanostep after release therefore fetches the opcode stored at microprogram address 0.
- R2: Each nanostep lasts two clocks. `step_o` reads 0 in the first clock and 1 in the second. Registers, the address counter, the condition register and the data RAM change only at the clock edge that ends the cycle where `step_o` is 1. At that edge the phase advances by one, modulo 16, unless the step loads the opcode register.
- R3: A step that loads the opcode register sets the phase to 0 at the same edge.
- R4: The control table is indexed by {opcode, phase, condition bit}. Every index without a programmed entry gives the fetch word: drive select 001, load select 000, address increment set.
- R5: The drive select picks the bus source. 001 is the microprogram byte at the address counter, using its low 9 bits. 010 is the ALU result. 100 is the data RAM at the memory address register. Any other code drives 00. When the increment flag is set and the step does not load the address counter, the counter advances by one after its current value has been used.
- R6: Load select 001 writes the address counter from the bus. With the half flag at 0 the low byte takes the bus and the high byte is cleared. With the half flag at 1 the high byte takes the bus and the low byte is kept.
- R7: The load select codes are 000 opcode register, 001 address counter, 010 register A, 011 register B, 100 data RAM at the memory address register, and 101 memory address register. Codes 110 and 111 load nothing.
- R8: The ALU codes are 100110 for A+B, 111110 for A−1, 110011 for FF, 101011 for B, and 111111 or any other code for A.
- R9: The condition register is 3 bits wide, and its MSB is the condition bit of the table index. Condition action 00 loads {Z, N, C} with Z in the MSB. Z is set when the result is 00, N is result bit 7, and C is bit 8 of the 9-bit sum or difference. Action 01 shifts the register one place toward the MSB and fills with 0. Action 11 holds the register.
- R10: Opcode 0A takes three operand bytes x, y, z and writes RAM[x]+RAM[y] to RAM[z], loading the condition register. The opcode runs for 7 phases, and the last phase is the fetch.
- R11: Opcode 17 takes one operand byte t. If the condition bit is 1, the address counter becomes 00t and execution continues there. Otherwise execution continues after the operand. Opcode 18 takes one operand, shifts the condition register once and then branches the same way, so it tests N.
- R12: Opcode 0C takes a low byte followed by a high byte and jumps to that 16-bit address.
- R13: Opcode 05 with operand x writes RAM[x]−1 to RAM[x] and loads the condition register. Opcode 06 with operands x and y copies RAM[x] to RAM[y]. Opcode 07 with operand x writes FF to RAM[x].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pre_we | input | 1 | Preload write strobe |
| pre_sel | input | 1 | Preload target: 0 microprogram memory, 1 data RAM |
| pre_addr | input | UMEM_AW | Preload address (data RAM uses the low 8 bits) |
| pre_data | input | 8 | Preload byte |
| bus_o | output | 8 | Current value of the shared bus |
| op_o | output | 8 | Opcode register |
| phase_o | output | 4 | Phase counter |
| step_o | output | 1 | 0 in the first cycle of a nanostep, 1 in the executing cycle |
| upc_o | output | 16 | Microprogram address counter |
| cond_o | output | 1 | Condition bit (MSB of the condition register) |

## Verification
The assertions check the following on every cycle: the first cycle of a step leaves opcode, phase and address stable, the phase advances or clears as the table word dictates, the counter increments or has its high byte cleared, and the condition register follows its latch and hold actions. The program-level effects can only be seen through the bench's scenarios. These are the sums and copies stored in RAM, the taken and untaken branches, the 16-bit jump across a page, the shifted N test and the one-step pass through an opcode with no nanoprogram. The bench runs a microprogram that chains all of these, compares the bus and state against a behavioural model on every clock, and checks the stored values read back by later copy steps.

// File: rtl/nseq_pkg.sv
package nseq_pkg;
  localparam int DW = 8;
  localparam int PCW = 2 * DW;
  localparam int CCW = 3;

  localparam logic [2:0] DR_NONE = 3'b000;
  localparam logic [2:0] DR_UMEM = 3'b001;
  localparam logic [2:0] DR_ALU  = 3'b010;
  localparam logic [2:0] DR_RAM  = 3'b100;

  localparam logic [2:0] LD_OP   = 3'b000;
  localparam logic [2:0] LD_ADR  = 3'b001;
  localparam logic [2:0] LD_A    = 3'b010;
  localparam logic [2:0] LD_B    = 3'b011;
  localparam logic [2:0] LD_RAM  = 3'b100;
  localparam logic [2:0] LD_MAR  = 3'b101;
  localparam logic [2:0] LD_NONE = 3'b110;

  localparam logic [5:0] ALU_ADD   = 6'b100110;
  localparam logic [5:0] ALU_DEC   = 6'b111110;
  localparam logic [5:0] ALU_ONES  = 6'b110011;
  localparam logic [5:0] ALU_PASSB = 6'b101011;
  localparam logic [5:0] ALU_NOP   = 6'b111111;

  localparam logic [1:0] CC_LATCH = 2'b00;
  localparam logic [1:0] CC_SHIFT = 2'b01;
  localparam logic [1:0] CC_HOLD  = 2'b11;

  typedef struct packed {
    logic       adr_inc;
    logic       adr_hi;
    logic [5:0] alu_fn;
    logic [1:0] cc;
    logic [2:0] dr;
    logic [2:0] ld;
  } nword_t;

  function automatic nword_t mk(logic inc, logic hi, logic [5:0] fn,
                                logic [1:0] cc, logic [2:0] dr, logic [2:0] ld);
    nword_t w;
    w.adr_inc = inc;
    w.adr_hi  = hi;
    w.alu_fn  = fn;
    w.cc      = cc;
    w.dr      = dr;
    w.ld      = ld;
    return w;
  endfunction

  localparam nword_t NW_FETCH = '{adr_inc: 1'b1, adr_hi: 1'b0, alu_fn: ALU_NOP,
                                  cc: CC_HOLD, dr: DR_UMEM, ld: LD_OP};
endpackage

// File: rtl/nseq_ctrl_table.sv
module nseq_ctrl_table
  import nseq_pkg::*;
(
  input  logic [DW-1:0] op,
  input  logic [3:0]    phase,
  input  logic          cond,
  output nword_t        word
);
  // R4: index {opcode, phase, cond}; unlisted entries fall back to fetch
  always_comb begin
    word = NW_FETCH;
    casez ({op, phase, cond})
      // 0A: RAM[z] = RAM[x] + RAM[y]  (R10)
      13'b00001010_0000_?, 13'b00001010_0010_?, 13'b00001010_0100_?:
        word = mk(1'b1, 1'b0, ALU_NOP, CC_HOLD, DR_UMEM, LD_MAR);
      13'b00001010_0001_?: word = mk(1'b0, 1'b0, ALU_NOP, CC_HOLD, DR_RAM, LD_A);
      13'b00001010_0011_?: word = mk(1'b0, 1'b0, ALU_NOP, CC_HOLD, DR_RAM, LD_B);
      13'b00001010_0101_?: word = mk(1'b0, 1'b0, ALU_ADD, CC_LATCH, DR_ALU, LD_RAM);
      // 05: RAM[x] = RAM[x] - 1  (R13)
      13'b00000101_0000_?: word = mk(1'b1, 1'b0, ALU_NOP, CC_HOLD, DR_UMEM, LD_MAR);
      13'b00000101_0001_?: word = mk(1'b0, 1'b0, ALU_NOP, CC_HOLD, DR_RAM, LD_A);
      13'b00000101_0010_?: word = mk(1'b0, 1'b0, ALU_DEC, CC_LATCH, DR_ALU, LD_RAM);
      // 06: RAM[y] = RAM[x]  (R13)
      13'b00000110_0000_?, 13'b00000110_0010_?:
        word = mk(1'b1, 1'b0, ALU_NOP, CC_HOLD, DR_UMEM, LD_MAR);
      13'b00000110_0001_?: word = mk(1'b0, 1'b0, ALU_NOP, CC_HOLD, DR_RAM, LD_B);
      13'b00000110_0011_?: word = mk(1'b0, 1'b0, ALU_PASSB, CC_HOLD, DR_ALU, LD_RAM);
      // 07: RAM[x] = FF  (R13)
      13'b00000111_0000_?: word = mk(1'b1, 1'b0, ALU_NOP, CC_HOLD, DR_UMEM, LD_MAR);
      13'b00000111_0001_?: word = mk(1'b0, 1'b0, ALU_ONES, CC_HOLD, DR_ALU, LD_RAM);
      // 0C: 16-bit jump  (R12)
      13'b00001100_0000_?: word = mk(1'b1, 1'b0, ALU_NOP, CC_HOLD, DR_UMEM, LD_A);
      13'b00001100_0001_?: word = mk(1'b1, 1'b0, ALU_NOP, CC_HOLD, DR_UMEM, LD_B);
      13'b00001100_0010_?: word = mk(1'b0, 1'b0, ALU_NOP, CC_HOLD, DR_ALU, LD_ADR);
      13'b00001100_0011_?: word = mk(1'b0, 1'b1, ALU_PASSB, CC_HOLD, DR_ALU, LD_ADR);
      // 17: branch on condition bit  (R11)
      13'b00010111_0000_?: word = mk(1'b1, 1'b0, ALU_NOP, CC_HOLD, DR_UMEM, LD_A);
      13'b00010111_0001_1: word = mk(1'b0, 1'b0, ALU_NOP, CC_HOLD, DR_ALU, LD_ADR);
      // 18: shift condition register, then branch  (R11)
      13'b00011000_0000_?: word = mk(1'b1, 1'b0, ALU_NOP, CC_HOLD, DR_UMEM, LD_A);
      13'b00011000_0001_?: word = mk(1'b0, 1'b0, ALU_NOP, CC_SHIFT, DR_NONE, LD_NONE);
      13'b00011000_0010_1: word = mk(1'b0, 1'b0, ALU_NOP, CC_HOLD, DR_ALU, LD_ADR);
      default: word = NW_FETCH;
    endcase
  end
endmodule

// File: rtl/nseq_alu.sv
module nseq_alu
  import nseq_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [5:0]    fn,
  output logic [DW-1:0] y,
  output logic [CCW-1:0] flags
);
  logic [DW:0] wide;

  always_comb begin
    case (fn)
      ALU_ADD:   wide = {1'b0, a} + {1'b0, b};
      ALU_DEC:   wide = {1'b0, a} - {{DW{1'b0}}, 1'b1};
      ALU_ONES:  wide = {1'b0, {DW{1'b1}}};
      ALU_PASSB: wide = {1'b0, b};
      default:   wide = {1'b0, a};
    endcase
    y     = wide[DW-1:0];
    flags = {(wide[DW-1:0] == '0), wide[DW-1], wide[DW]};  // {Z,N,C}
  end
endmodule

// File: rtl/nseq_ccsr.sv
module nseq_ccsr
  import nseq_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [1:0]     mode,
  input  logic [CCW-1:0] flags,
  output logic           cond
);
  logic [CCW-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (en) begin
      case (mode)
        CC_LATCH: sr_d = flags;
        CC_SHIFT: sr_d = {sr_q[CCW-2:0], 1'b0};
        default:  sr_d = sr_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign cond = sr_q[CCW-1];

  AST_CC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == CC_HOLD) |=> $stable(cond)); // R9
  AST_CC_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == CC_LATCH) |=> (cond == $past(flags[CCW-1]))); // R9
endmodule

// File: rtl/nseq_core.sv
module nseq_core
  import nseq_pkg::*;
#(
  parameter int UMEM_AW = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pre_we,
  input  logic               pre_sel,
  input  logic [UMEM_AW-1:0] pre_addr,
  input  logic [DW-1:0]      pre_data,
  output logic [DW-1:0]      bus_o,
  output logic [DW-1:0]      op_o,
  output logic [3:0]         phase_o,
  output logic               step_o,
  output logic [PCW-1:0]     upc_o,
  output logic               cond_o
);
  localparam int UDEPTH = 2 ** UMEM_AW;
  localparam int RDEPTH = 2 ** DW;

  logic [1:0]     rsync_q;
  logic           rst_ni;
  logic [DW-1:0]  op_q, op_d, a_q, a_d, b_q, b_d, mar_q, mar_d;
  logic [3:0]     phase_q, phase_d;
  logic           exec_q, exec_d;
  logic [PCW-1:0] upc_q, upc_d;
  logic [DW-1:0]  bus, alu_y;
  logic [CCW-1:0] alu_flags;
  logic           cond, ram_we;
  nword_t         w;

  logic [DW-1:0] umem [UDEPTH];
  logic [DW-1:0] ram  [RDEPTH];

  // reset release synchroniser
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  nseq_ctrl_table u_tab (.op(op_q), .phase(phase_q), .cond(cond), .word(w));
  nseq_alu        u_alu (.a(a_q), .b(b_q), .fn(w.alu_fn), .y(alu_y), .flags(alu_flags));
  nseq_ccsr       u_cc  (.clk(clk), .rst_n(rst_ni), .en(exec_q), .mode(w.cc),
                         .flags(alu_flags), .cond(cond));

  // bus source mux (R5)
  always_comb begin
    case (w.dr)
      DR_UMEM: bus = umem[upc_q[UMEM_AW-1:0]];
      DR_ALU:  bus = alu_y;
      DR_RAM:  bus = ram[mar_q];
      default: bus = '0;
    endcase
  end

  // next state
  always_comb begin
    op_d    = op_q;
    phase_d = phase_q;
    a_d     = a_q;
    b_d     = b_q;
    mar_d   = mar_q;
    upc_d   = upc_q;
    exec_d  = ~exec_q;
    if (exec_q) begin
      phase_d = phase_q + 4'd1;
      if (w.adr_inc) upc_d = upc_q + 1'b1;
      case (w.ld)
        LD_OP: begin
          op_d    = bus;
          phase_d = '0;
        end
        LD_ADR:  upc_d = w.adr_hi ? {bus, upc_q[DW-1:0]} : {{DW{1'b0}}, bus};
        LD_A:    a_d   = bus;
        LD_B:    b_d   = bus;
        LD_MAR:  mar_d = bus;
        default: ;
      endcase
    end
  end

  assign ram_we = exec_q && (w.ld == LD_RAM);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= '0;
      phase_q <= '0;
      exec_q  <= 1'b0;
      upc_q   <= '0;
      a_q     <= '0;
      b_q     <= '0;
      mar_q   <= '0;
    end else begin
      op_q    <= op_d;
      phase_q <= phase_d;
      exec_q  <= exec_d;
      upc_q   <= upc_d;
      a_q     <= a_d;
      b_q     <= b_d;
      mar_q   <= mar_d;
    end
  end

  always_ff @(posedge clk) begin
    if (pre_we && !pre_sel) umem[pre_addr] <= pre_data;
  end

  always_ff @(posedge clk) begin
    if (pre_we && pre_sel) ram[pre_addr[DW-1:0]] <= pre_data;
    else if (ram_we)       ram[mar_q] <= bus;
  end

  assign bus_o   = bus;
  assign op_o    = op_q;
  assign phase_o = phase_q;
  assign step_o  = exec_q;
  assign upc_o   = upc_q;
  assign cond_o  = cond;

  AST_SETUP_STABLE: assert property (@(posedge clk) disable iff (!rst_ni)
    !exec_q |=> ($stable(op_q) && $stable(phase_q) && $stable(upc_q))); // R2
  AST_PHASE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_ni)
    (exec_q && w.ld != LD_OP) |=> (phase_q == $past(phase_q) + 4'd1)); // R2
  AST_PHASE_CLEAR: assert property (@(posedge clk) disable iff (!rst_ni)
    (exec_q && w.ld == LD_OP) |=> (phase_q == 4'd0 && op_q == $past(bus))); // R3
  AST_UPC_STEP: assert property (@(posedge clk) disable iff (!rst_ni)
    (exec_q && w.adr_inc && w.ld != LD_ADR) |=> (upc_q == $past(upc_q) + 16'd1)); // R5
  AST_UPC_LOW_LOAD: assert property (@(posedge clk) disable iff (!rst_ni)
    (exec_q && w.ld == LD_ADR && !w.adr_hi) |=> (upc_q[PCW-1:DW] == '0)); // R6
endmodule

// File: tb/test_nseq_core.sv
module test_nseq_core;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int UAW = 9;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic           rst_n;
  logic           pre_we, pre_sel;
  logic [UAW-1:0] pre_addr;
  logic [7:0]     pre_data;
  logic [7:0]     bus_o, op_o;
  logic [3:0]     phase_o;
  logic           step_o, cond_o;
  logic [15:0]    upc_o;

  nseq_core #(.UMEM_AW(UAW)) i_nseq_core (
    .clk(clk), .rst_n(rst_n), .pre_we(pre_we), .pre_sel(pre_sel),
    .pre_addr(pre_addr), .pre_data(pre_data), .bus_o(bus_o), .op_o(op_o),
    .phase_o(phase_o), .step_o(step_o), .upc_o(upc_o), .cond_o(cond_o));

  int vecs = 0;
  int bad  = 0;
  bit done = 0;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  logic [7:0] mu [512];
  logic [7:0] mr [256];
  int m_op, m_ph, m_step, m_upc, m_a, m_b, m_mar, m_sr, rel;

  // source: 0 none,1 prog,2 alu,4 ram ; dest: 0 op,1 adr,2 A,3 B,4 ram,5 mar,6 none
  // fn: 0 A,1 add,2 dec,3 ones,4 B ; cc: 0 latch,1 shift,3 hold
  task automatic m_word(input int op, input int ph, input int cnd,
                        output int src, output int dst, output int fn,
                        output int inc, output int hi, output int cc);
    src = 1; dst = 0; fn = 0; inc = 1; hi = 0; cc = 3;
    if (op == 'h0A) begin
      if (ph == 0 || ph == 2 || ph == 4) dst = 5;
      else if (ph == 1) begin src = 4; dst = 2; inc = 0; end
      else if (ph == 3) begin src = 4; dst = 3; inc = 0; end
      else if (ph == 5) begin src = 2; fn = 1; dst = 4; cc = 0; inc = 0; end
    end else if (op == 'h05) begin
      if (ph == 0) dst = 5;
      else if (ph == 1) begin src = 4; dst = 2; inc = 0; end
      else if (ph == 2) begin src = 2; fn = 2; dst = 4; cc = 0; inc = 0; end
    end else if (op == 'h06) begin
      if (ph == 0 || ph == 2) dst = 5;
      else if (ph == 1) begin src = 4; dst = 3; inc = 0; end
      else if (ph == 3) begin src = 2; fn = 4; dst = 4; inc = 0; end
    end else if (op == 'h07) begin
      if (ph == 0) dst = 5;
      else if (ph == 1) begin src = 2; fn = 3; dst = 4; inc = 0; end
    end else if (op == 'h0C) begin
      if (ph == 0) dst = 2;
      else if (ph == 1) dst = 3;
      else if (ph == 2) begin src = 2; dst = 1; inc = 0; end
      else if (ph == 3) begin src = 2; fn = 4; dst = 1; hi = 1; inc = 0; end
    end else if (op == 'h17) begin
      if (ph == 0) dst = 2;
      else if (ph == 1 && cnd == 1) begin src = 2; dst = 1; inc = 0; end
    end else if (op == 'h18) begin
      if (ph == 0) dst = 2;
      else if (ph == 1) begin src = 0; dst = 6; cc = 1; inc = 0; end
      else if (ph == 2 && cnd == 1) begin src = 2; dst = 1; inc = 0; end
    end
  endtask

  task automatic m_alu(input int fn, output int y, output int fl);
    int r;
    case (fn)
      1: r = m_a + m_b;
      2: r = (m_a == 0) ? 'h1FF : m_a - 1;
      3: r = 'hFF;
      4: r = m_b;
      default: r = m_a;
    endcase
    y  = r & 'hFF;
    fl = ((y == 0) ? 4 : 0) | (((y >> 7) & 1) << 1) | ((r >> 8) & 1);
  endtask

  task automatic m_eval(output int bus, output int dst, output int inc,
                        output int hi, output int cc, output int fl);
    int src, fn, y;
    m_word(m_op, m_ph, (m_sr >> 2) & 1, src, dst, fn, inc, hi, cc);
    m_alu(fn, y, fl);
    case (src)
      1: bus = int'(mu[m_upc % 512]);
      2: bus = y;
      4: bus = int'(mr[m_mar]);
      default: bus = 0;
    endcase
  endtask

  task automatic m_apply();
    int bus, dst, inc, hi, cc, fl;
    m_eval(bus, dst, inc, hi, cc, fl);
    m_ph = (m_ph + 1) & 15;
    if (inc == 1) m_upc = (m_upc + 1) & 'hFFFF;
    case (dst)
      0: begin m_op = bus; m_ph = 0; end
      1: m_upc = (hi == 1) ? ((bus << 8) | (m_upc & 'hFF)) : bus;
      2: m_a = bus;
      3: m_b = bus;
      4: mr[m_mar] = bus[7:0];
      5: m_mar = bus;
      default: ;
    endcase
    if (cc == 0) m_sr = fl;
    else if (cc == 1) m_sr = (m_sr << 1) & 7;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      rel = 0; m_op = 0; m_ph = 0; m_step = 0; m_upc = 0;
      m_a = 0; m_b = 0; m_mar = 0; m_sr = 0;
    end else begin
      rel++;
      if (rel >= 3) begin
        if (m_step == 1) m_apply();
        m_step = 1 - m_step;
      end
    end
  end

  // ---------------- per-cycle comparison and captures ----------------
  logic [7:0] copy_q [$];
  logic [7:0] dec_q [$];
  logic       cond17_q [$];
  int  seen07_upc = -1;
  int  seen55_upc = -1;
  int  cnt55 = 0;

  always @(negedge clk) begin
    int ebus, d, i, h, c, f;
    if (rst_n && !done && rel >= 2) begin
      m_eval(ebus, d, i, h, c, f);
      chk("R5 bus", 32'(bus_o), 32'(ebus));
      chk("R7 opcode", 32'(op_o), 32'(m_op));
      chk("R3 phase", 32'(phase_o), 32'(m_ph));
      chk("R2 step", 32'(step_o), 32'(m_step));
      chk("R6 address", 32'(upc_o), 32'(m_upc));
      chk("R9 cond", 32'(cond_o), 32'((m_sr >> 2) & 1));
      if (rel == 2) chk("R1 first fetch byte", 32'(bus_o), 32'h0A);
      if (op_o == 8'h06 && phase_o == 4'd3 && step_o) copy_q.push_back(bus_o);
      if (op_o == 8'h05 && phase_o == 4'd2 && step_o) dec_q.push_back(bus_o);
      if (op_o == 8'h17 && phase_o == 4'd0 && !step_o) cond17_q.push_back(cond_o);
      if (op_o == 8'h07 && seen07_upc < 0) seen07_upc = int'(upc_o);
      if (op_o == 8'h55) begin
        cnt55++;
        if (seen55_upc < 0) seen55_upc = int'(upc_o);
      end
    end
  end

  task automatic put(input bit sel, input int addr, input int data);
    @(negedge clk);
    pre_we = 1'b1; pre_sel = sel; pre_addr = UAW'(addr); pre_data = 8'(data);
    if (sel) mr[addr] = 8'(data); else mu[addr] = 8'(data);
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  task automatic prog(input int addr, input int data);
    put(1'b0, addr, data);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; pre_we = 1'b0; pre_sel = 1'b0; pre_addr = '0; pre_data = '0;
    // data RAM operands
    put(1'b1, 'h10, 'h25);
    put(1'b1, 'h11, 'h17);
    put(1'b1, 'h14, 'h01);
    // microprogram
    prog('h00, 'h0A); prog('h01, 'h10); prog('h02, 'h11); prog('h03, 'h12);
    prog('h04, 'h06); prog('h05, 'h12); prog('h06, 'h13);
    prog('h07, 'h17); prog('h08, 'h40);
    prog('h09, 'h05); prog('h0A, 'h14);
    prog('h0B, 'h17); prog('h0C, 'h20);
    prog('h0D, 'h07); prog('h0E, 'h15);
    prog('h20, 'h0C); prog('h21, 'h00); prog('h22, 'h01);
    prog('h100, 'h07); prog('h101, 'h15);
    prog('h102, 'h06); prog('h103, 'h15); prog('h104, 'h16);
    prog('h105, 'h06); prog('h106, 'h13); prog('h107, 'h17);
    prog('h108, 'h05); prog('h109, 'h15);
    prog('h10A, 'h18); prog('h10B, 'h30);
    prog('h30, 'h55);
    prog('h31, 'h0C); prog('h32, 'h31); prog('h33, 'h00);
    @(negedge clk);
    chk("R1 reset address", 32'(upc_o), 32'h0);
    chk("R1 reset phase", 32'(phase_o), 32'h0);
    chk("R1 reset opcode", 32'(op_o), 32'h0);
    chk("R1 reset step", 32'(step_o), 32'h0);
    rst_n = 1'b1;
    repeat (500) @(negedge clk);
    done = 1;
    chk("R10 copy count", 32'(copy_q.size()), 32'd3);
    if (copy_q.size() == 3) begin
      chk("R10 sum stored", 32'(copy_q[0]), 32'h3C);
      chk("R8 fill value via copy R13", 32'(copy_q[1]), 32'hFF);
      chk("R10 sum copied again", 32'(copy_q[2]), 32'h3C);
    end
    chk("R13 decrement count", 32'(dec_q.size()), 32'd2);
    if (dec_q.size() == 2) begin
      chk("R8 A-1 of 01", 32'(dec_q[0]), 32'h00);
      chk("R8 A-1 of FF", 32'(dec_q[1]), 32'hFE);
    end
    chk("R9 branch cond samples", 32'(cond17_q.size()), 32'd2);
    if (cond17_q.size() == 2) begin
      chk("R9 Z clear after add", 32'(cond17_q[0]), 32'd0);
      chk("R9 Z set after decrement", 32'(cond17_q[1]), 32'd1);
    end
    chk("R12 jump target R11 taken", 32'(seen07_upc), 32'h101);
    chk("R11 shifted N branch R6 high cleared", 32'(seen55_upc), 32'h31);
    chk("R4 unprogrammed opcode one step", 32'(cnt55), 32'd2);
    summary();
  end
endmodule